// File: doc/BRIEF.md
# Threshold Window Interrupt with Persistence Filter

This block watches a stream of conversion results and raises an interrupt when the results stay outside a programmable window for long enough. Each result arrives with a one-cycle valid strobe. It is compared against a low and a high bound. A run counter tracks how many valid results in a row have fallen outside the window. When the run reaches the length selected by a two-bit persistence code, a sticky flag is set and an active-low interrupt line is pulled low.

The flag and the interrupt line stay asserted until the surrounding register logic sends a one-cycle clear pulse, which it does when software reads the status register. That logic also sends a one-cycle pulse whenever any threshold register is written. Both pulses discard the run in progress. With the reset-time bounds of 0x0000 (low) and 0xFFFF (high), no 16-bit result can ever be outside the window.

Top module: `lux_window_irq`

## Requirements
- R1: After synchronous reset, `irq_flag` is 0 and `irq_n` is 1.
- R2: A result is outside the window only when it is strictly less than `thr_lo` or strictly greater than `thr_hi`. A result equal to either bound counts as inside. With `thr_lo`=0x0000 and `thr_hi`=0xFFFF, no result ever sets the flag.
- R3: The `persist_code` input selects the number of consecutive out-of-window results that trigger the interrupt: 2'b00 needs 1, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16.
- R4: A valid result that lies inside the window resets the run of consecutive out-of-window results to zero.
- R5: Once set, `irq_flag` stays 1 until a clear pulse arrives, whatever results follow. `irq_n` is always the inverse of `irq_flag`.
- R6: A `flag_clr` pulse clears `irq_flag` (so `irq_n` returns to 1) and resets the run. If a triggering result arrives in the same cycle as the clear, the clear wins and the flag ends up 0.
- R7: A `thr_wr` pulse resets the run. A result that arrives in the same cycle as the pulse is not counted. The flag is not changed by `thr_wr`.
- R8: The flag is set on the clock edge that captures the triggering result, and is visible on the outputs in the following cycle. Cycles in which `res_valid` is low neither add to the run nor break it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | One-cycle strobe marking a new conversion result |
| res_data | input | DATA_W | Conversion result |
| thr_lo | input | DATA_W | Low bound of the window |
| thr_hi | input | DATA_W | High bound of the window |
| thr_wr | input | 1 | Pulse when any threshold register is written |
| persist_code | input | 2 | Encoded run length needed to trigger |
| flag_clr | input | 1 | Pulse when the status register is read |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The assertions assume that `flag_clr` and `thr_wr` are single-cycle pulses. They also assume that `res_data`, `thr_lo` and `thr_hi` are stable and known whenever `res_valid` is high. They allow `persist_code` to change at any time. The stimulus changes every input only on the falling clock edge. In the random phase, the thresholds are redrawn only together with a `thr_wr` pulse, and clears and threshold writes are kept rare so that runs of 16 can still complete. Result values are drawn close to the bounds so that the equality cases come up often.

// File: rtl/lux_irq_pkg.sv
package lux_irq_pkg;

    // Longest run the persistence code can ask for, and the counter width for it.
    localparam int MAX_RUN = 16;
    localparam int RUN_W   = $clog2(MAX_RUN + 1);

    typedef enum logic [1:0] {
        PERSIST_1  = 2'b00,
        PERSIST_4  = 2'b01,
        PERSIST_8  = 2'b10,
        PERSIST_16 = 2'b11
    } persist_e;

    typedef struct packed {
        logic below;
        logic above;
    } win_t;

    function automatic logic [RUN_W-1:0] persist_need(input persist_e code);
        logic [RUN_W-1:0] n;
        case (code)
            PERSIST_1:  n = RUN_W'(1);
            PERSIST_4:  n = RUN_W'(4);
            PERSIST_8:  n = RUN_W'(8);
            default:    n = RUN_W'(MAX_RUN);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lux_win_cmp.sv
module lux_win_cmp
    import lux_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    output win_t              win
);
    // Equality with a bound counts as inside the window.
    always_comb begin
        win.below = (data < lo);
        win.above = (data > hi);
    end
endmodule

// File: rtl/lux_run_count.sv
module lux_run_count
    import lux_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic             outside,
    input  logic             flush,
    input  logic [RUN_W-1:0] need,
    output logic             hit
);
    logic [RUN_W-1:0] run_q;
    logic [RUN_W:0]   run_inc;

    assign run_inc = {1'b0, run_q} + 1'b1;
    assign hit     = res_valid && outside && !flush && (run_inc >= {1'b0, need});

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            run_q <= '0;
        end else if (res_valid) begin
            if (!outside)
                run_q <= '0;
            else if (run_inc >= {1'b0, need})
                run_q <= need;
            else
                run_q <= run_inc[RUN_W-1:0];
        end
    end

    // R4: an inside result empties the run
    a_r4_inside_resets: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !outside) |=> (run_q == '0));

    // R6 / R7: a clear or a threshold write empties the run
    a_r6_flush_resets: assert property (@(posedge clk) disable iff (rst)
        flush |=> (run_q == '0));

    // R3: the run never exceeds the longest persistence setting
    a_r3_run_bounded: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(MAX_RUN));

    // R8: idle cycles leave the run unchanged
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !flush) |=> $stable(run_q));
endmodule

// File: rtl/lux_irq_latch.sv
module lux_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    output logic flag,
    output logic flag_n
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag   <= 1'b0;
            flag_n <= 1'b1;
        end else if (hit) begin
            flag   <= 1'b1;
            flag_n <= 1'b0;
        end
    end

    // R5: the flag is sticky until a clear arrives
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R5: the pin is the inverse of the flag
    a_r5_pin_inverse: assert property (@(posedge clk) disable iff (rst)
        flag_n == !flag);

    // R6: a clear always wins
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);

    // R8: the flag rises only after a trigger
    a_r8_rise_needs_hit: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(hit));
endmodule

// File: rtl/lux_window_irq.sv
module lux_window_irq
    import lux_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic              thr_wr,
    input  logic [1:0]        persist_code,
    input  logic              flag_clr,
    output logic              irq_flag,
    output logic              irq_n
);
    win_t             win;
    logic             outside;
    logic             hit;
    logic [RUN_W-1:0] need;

    assign outside = win.below || win.above;
    assign need    = persist_need(persist_e'(persist_code));

    lux_win_cmp #(.DATA_W(DATA_W)) u_cmp (
        .data (res_data),
        .lo   (thr_lo),
        .hi   (thr_hi),
        .win  (win)
    );

    lux_run_count u_run (
        .clk       (clk),
        .rst       (rst),
        .res_valid (res_valid),
        .outside   (outside),
        .flush     (flag_clr || thr_wr),
        .need      (need),
        .hit       (hit)
    );

    lux_irq_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .clr    (flag_clr),
        .flag   (irq_flag),
        .flag_n (irq_n)
    );

    // R2: a trigger only comes from a result strictly outside the bounds
    a_r2_hit_outside: assert property (@(posedge clk) disable iff (rst)
        hit |-> (res_data < thr_lo || res_data > thr_hi));

    // R7: a threshold write never triggers
    a_r7_write_no_hit: assert property (@(posedge clk) disable iff (rst)
        thr_wr |-> !hit);
endmodule

// File: tb/lux_window_irq_test.sv
module lux_window_irq_test;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          res_valid;
    logic [DW-1:0] res_data;
    logic [DW-1:0] thr_lo;
    logic [DW-1:0] thr_hi;
    logic          thr_wr;
    logic [1:0]    persist_code;
    logic          flag_clr;
    logic          irq_flag;
    logic          irq_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    // Reference state kept by the bench.
    int  m_run  = 0;
    bit  m_flag = 0;

    always #5 clk = ~clk;

    lux_window_irq #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .thr_wr(thr_wr),
        .persist_code(persist_code), .flag_clr(flag_clr),
        .irq_flag(irq_flag), .irq_n(irq_n)
    );

    function automatic int need_of(input logic [1:0] c);
        case (c)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic bit is_out(input logic [DW-1:0] d, input logic [DW-1:0] lo,
                                  input logic [DW-1:0] hi);
        return (d < lo) || (d > hi);
    endfunction

    task automatic check(input string tag);
        n_tests++;
        if (irq_flag !== m_flag || irq_n !== !m_flag) begin
            n_fail++;
            $display("FAIL %s: flag=%0b irq_n=%0b expected flag=%0b irq_n=%0b",
                     tag, irq_flag, irq_n, m_flag, !m_flag);
        end
    endtask

    // Applies one cycle of stimulus at the falling edge, updates the reference
    // model, and compares the outputs shortly after the rising edge.
    task automatic cyc(input bit v, input logic [DW-1:0] d, input bit wr,
                       input bit clr, input string tag);
        res_valid = v; res_data = d; thr_wr = wr; flag_clr = clr;
        if (clr) begin
            m_run = 0; m_flag = 0;
        end else if (wr) begin
            m_run = 0;
        end else if (v) begin
            if (is_out(d, thr_lo, thr_hi)) begin
                if (m_run + 1 >= need_of(persist_code)) m_flag = 1;
                m_run = (m_run + 1 > need_of(persist_code)) ? need_of(persist_code) : m_run + 1;
            end else begin
                m_run = 0;
            end
        end
        @(posedge clk);
        #2;
        check(tag);
        @(negedge clk);
        res_valid = 0; thr_wr = 0; flag_clr = 0;
    endtask

    task automatic set_thr(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
        thr_lo = lo; thr_hi = hi;
        cyc(0, '0, 1, 0, "R7 thr write");
    endtask

    task automatic clear();
        cyc(0, '0, 0, 1, "R6 clear");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst = 1; res_valid = 0; res_data = '0; thr_lo = 16'h0000; thr_hi = 16'hFFFF;
        thr_wr = 0; persist_code = 2'b00; flag_clr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check("R1 reset");

        // R2 reset bounds: nothing is ever outside
        for (int i = 0; i < 20; i++) cyc(1, DW'($urandom), 0, 0, "R2 default bounds");
        cyc(1, 16'h0000, 0, 0, "R2 default bounds min");
        cyc(1, 16'hFFFF, 0, 0, "R2 default bounds max");

        // R2 equality is inside, strict violations trigger
        set_thr(16'd100, 16'd200);
        cyc(1, 16'd100, 0, 0, "R2 equal low");
        cyc(1, 16'd200, 0, 0, "R2 equal high");
        cyc(1, 16'd99, 0, 0, "R2 below low");
        clear();
        cyc(1, 16'd201, 0, 0, "R2 above high");
        clear();

        // R3 persistence of 4
        persist_code = 2'b01;
        for (int i = 0; i < 3; i++) cyc(1, 16'd5, 0, 0, "R3 run 4 short");
        cyc(1, 16'd5, 0, 0, "R3 run 4 reached");
        clear();

        // R3 persistence of 8
        persist_code = 2'b10;
        for (int i = 0; i < 7; i++) cyc(1, 16'd900, 0, 0, "R3 run 8 short");
        cyc(1, 16'd900, 0, 0, "R3 run 8 reached");
        clear();

        // R3 persistence of 16
        persist_code = 2'b11;
        for (int i = 0; i < 15; i++) cyc(1, 16'd1, 0, 0, "R3 run 16 short");
        cyc(1, 16'd1, 0, 0, "R3 run 16 reached");
        clear();

        // R4 an inside result breaks the run
        persist_code = 2'b01;
        for (int i = 0; i < 3; i++) cyc(1, 16'd5, 0, 0, "R4 pre");
        cyc(1, 16'd150, 0, 0, "R4 inside");
        for (int i = 0; i < 3; i++) cyc(1, 16'd5, 0, 0, "R4 restart");
        cyc(1, 16'd5, 0, 0, "R4 fourth after restart");

        // R5 sticky through inside results
        for (int i = 0; i < 5; i++) cyc(1, 16'd150, 0, 0, "R5 sticky");
        for (int i = 0; i < 3; i++) cyc(0, '0, 0, 0, "R5 sticky idle");
        clear();

        // R8 idle gaps do not break a run
        for (int i = 0; i < 3; i++) begin
            cyc(1, 16'd300, 0, 0, "R8 gapped");
            cyc(0, 16'd150, 0, 0, "R8 gap");
        end
        cyc(1, 16'd300, 0, 0, "R8 gapped reached");
        clear();

        // R6 clear wins over a same-cycle trigger, and resets the run
        for (int i = 0; i < 3; i++) cyc(1, 16'd5, 0, 0, "R6 pre");
        cyc(1, 16'd5, 0, 1, "R6 clear with trigger");
        for (int i = 0; i < 3; i++) cyc(1, 16'd5, 0, 0, "R6 after clear");
        cyc(1, 16'd5, 0, 0, "R6 fourth after clear");
        clear();

        // R7 threshold write resets the run and drops a same-cycle result
        for (int i = 0; i < 3; i++) cyc(1, 16'd5, 0, 0, "R7 pre");
        cyc(1, 16'd5, 1, 0, "R7 write with result");
        for (int i = 0; i < 3; i++) cyc(1, 16'd5, 0, 0, "R7 after write");
        cyc(1, 16'd5, 0, 0, "R7 fourth after write");
        // R7 write leaves the flag alone
        cyc(0, '0, 1, 0, "R7 flag kept");
        clear();

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 2) begin
                logic [DW-1:0] lo = DW'($urandom_range(0, 1000));
                set_thr(lo, lo + DW'($urandom_range(0, 500)));
            end else if (r < 4) begin
                clear();
            end else if (r < 6) begin
                persist_code = 2'($urandom);
                cyc(0, '0, 0, 0, "R3 random code");
            end else begin
                logic [DW-1:0] d;
                case ($urandom_range(0, 3))
                    0: d = thr_lo - DW'($urandom_range(0, 2));
                    1: d = thr_hi + DW'($urandom_range(0, 2));
                    2: d = DW'($urandom_range(0, 1600));
                    default: d = thr_lo + DW'($urandom_range(0, 3));
                endcase
                cyc($urandom_range(0, 3) != 0, d, 0, 0, "R5 random");
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule